// File: doc/BRIEF.md
# Triple Match-and-Reload Timer

This peripheral holds three identical 32-bit timers behind one small register port. Each timer has a live count, a reload value and two compare values. It counts up or down, either on every bus clock cycle or on rising edges of its own external tick input. When it wraps, it takes its count from the reload value and raises an overflow event. Each compare value raises its own event on the tick that brings the count to that value. The count keeps running after a compare hit.

One shared control word holds, for every timer, an enable bit, a tick-source select, an overflow-interrupt enable and a direction bit. Nine event flags sit in one shared status word with a matching mask word. A single registered interrupt line is the OR of the flags that are unmasked. Software typically uses the block in two ways:
- A periodic tick: count up from a reload value of `0xFFFFFFFF - (P-1)` and take the overflow.
- A one-shot deadline: program a compare value at "current count + N".

Top module: `trio_timer`

## Requirements
- R1: Reset clears every count, reload and compare value, the control word and the status word. It sets the mask word to 0x1FF and drives `irq` low.
- R2: Address map. Timer n (n = 0..2) occupies base 0x10·n, with count at +0x0, reload at +0x4, compare 1 at +0x8 and compare 2 at +0xC. The control word is at 0x30 and reads back its low 12 bits. The status word is at 0x34. The mask word is at 0x38 and reads back its low 9 bits. Read data appears on `bus_rdata` in the cycle after a read access.
- R3: Up-counting. A timer whose direction bit 9+n is 1 and whose enable bit 3n is 1 increments by one per tick. On a tick taken at 0xFFFFFFFF it loads its reload value and sets status bit 3n+2 (overflow).
- R4: Down-counting. With direction bit 9+n at 0, the timer decrements by one per tick. On a tick taken at 0 it loads its reload value and sets status bit 3n+2.
- R5: A tick whose resulting count equals compare 1 sets status bit 3n; one that equals compare 2 sets status bit 3n+1. Counting continues afterwards.
- R6: A bus write to a count register takes effect at once and wins over a tick in the same cycle. A read of a running count returns its value at the read cycle.
- R7: A timer whose enable bit is 0 keeps its count unchanged.
- R8: With tick-source bit 3n+1 set, the timer advances once per rising edge of `ext_tick[n]`, seen through a two-flop synchroniser. A steady level causes no ticks. With the bit clear, it advances every clock cycle.
- R9: A status write clears each bit written as 0 and leaves each bit written as 1 unchanged. An event in the same cycle as a clearing write leaves its bit set.
- R10: Status bits set whatever the mask. `irq` rises one cycle after a status bit is set whose mask bit is 0. Overflow bits also need control bit 3n+2. A mask bit of 1 blocks its status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read for the access |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ext_tick | input | 3 | Asynchronous external tick, one per timer |
| irq | output | 1 | Registered combined interrupt |

## Verification
The step assertions assume that a timer's tick source and direction come only from the control word. They also assume that a count changes only through a tick or a count-register write, so each check is qualified by "no write to this count in this cycle". The sticky-status check assumes that only a status-register write can clear a flag. The bench drives each access as a single-cycle strobe that it sets up on the falling edge. It changes `ext_tick` only between edges, and it holds each level for several cycles so every rising edge survives the synchroniser. To keep tick counts exact, the bench starts and stops each timer by writing the control word, so a run of N cycles gives exactly N ticks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Word offset of a register inside one timer's 16-byte block.
  typedef enum logic [1:0] {
    OFS_CNT  = 2'd0,
    OFS_LOAD = 2'd1,
    OFS_CMP1 = 2'd2,
    OFS_CMP2 = 2'd3
  } tmr_ofs_e;

  // Per-timer event triple; packing order matches status bits 3n..3n+2.
  typedef struct packed {
    logic ovf;
    logic cmp2;
    logic cmp1;
  } tmr_evt_t;
endpackage

// File: rtl/tmr_tick_sync.sv
module tmr_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sq;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sq   <= '0;
      last <= 1'b0;
    end else begin
      sq   <= {sq[STAGES-2:0], async_in};
      last <= sq[STAGES-1];
    end
  end

  assign rise = sq[STAGES-1] & ~last;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          up,
  input  logic          tick,
  input  logic          wr_en,
  input  tmr_ofs_e      wr_sel,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] load,
  output logic [CW-1:0] cmp1,
  output logic [CW-1:0] cmp2,
  output tmr_evt_t      evt
);
  localparam logic [CW-1:0] TOP = '1;

  logic          step, wrap, cnt_wr;
  logic [CW-1:0] nxt;

  assign cnt_wr = wr_en && (wr_sel == OFS_CNT);
  assign step   = en && tick && !cnt_wr;
  assign wrap   = up ? (cnt == TOP) : (cnt == '0);
  assign nxt    = wrap ? load : (up ? cnt + CW'(1) : cnt - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      load <= '0;
      cmp1 <= '0;
      cmp2 <= '0;
    end else begin
      if (cnt_wr)    cnt <= wr_data;
      else if (step) cnt <= nxt;
      if (wr_en && wr_sel == OFS_LOAD) load <= wr_data;
      if (wr_en && wr_sel == OFS_CMP1) cmp1 <= wr_data;
      if (wr_en && wr_sel == OFS_CMP2) cmp2 <= wr_data;
    end
  end

  assign evt.ovf  = step && wrap;
  assign evt.cmp1 = step && (nxt == cmp1);
  assign evt.cmp2 = step && (nxt == cmp2);
endmodule

// File: rtl/tmr_irq_ctl.sv
module tmr_irq_ctl #(
  parameter int NEV = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NEV-1:0] evt,
  input  logic [NEV-1:0] gate,
  input  logic           st_wr,
  input  logic           msk_wr,
  input  logic [NEV-1:0] wdata,
  output logic [NEV-1:0] status,
  output logic [NEV-1:0] mask,
  output logic           irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      mask   <= '1;
      irq    <= 1'b0;
    end else begin
      status <= (st_wr ? (status & wdata) : status) | evt;
      if (msk_wr) mask <= wdata;
      irq <= |(status & ~mask & gate);
    end
  end
endmodule

// File: rtl/trio_timer.sv
module trio_timer
  import tmr_pkg::*;
#(
  parameter int NTMR        = 3,
  parameter int CW          = 32,
  parameter int AW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [CW-1:0]   bus_wdata,
  output logic [CW-1:0]   bus_rdata,
  input  logic [NTMR-1:0] ext_tick,
  output logic            irq
);
  localparam int NEV       = 3 * NTMR;
  localparam int CTRL_W    = 4 * NTMR;
  localparam int BLK_W     = AW - 4;
  localparam int CTRL_ADDR = NTMR * 16;
  localparam int STAT_ADDR = CTRL_ADDR + 4;
  localparam int MASK_ADDR = CTRL_ADDR + 8;

  logic             wr_acc, rd_acc;
  logic [BLK_W-1:0] blk;
  tmr_ofs_e         ofs;
  logic             ctrl_hit, stat_hit, mask_hit;

  logic [CTRL_W-1:0]          ctrl_q;
  logic [NTMR-1:0][CW-1:0]    cnt_v, load_v, cmp1_v, cmp2_v;
  logic [NTMR-1:0]            tmr_hit, rise;
  logic [NEV-1:0]             evt_all, gate, status_q, mask_q;
  logic [CW-1:0]              rd_mux;

  assign wr_acc   = bus_sel && bus_wr;
  assign rd_acc   = bus_sel && !bus_wr;
  assign blk      = bus_addr[AW-1:4];
  assign ofs      = tmr_ofs_e'(bus_addr[3:2]);
  assign ctrl_hit = (bus_addr == AW'(CTRL_ADDR));
  assign stat_hit = (bus_addr == AW'(STAT_ADDR));
  assign mask_hit = (bus_addr == AW'(MASK_ADDR));

  always_ff @(posedge clk) begin
    if (rst)                   ctrl_q <= '0;
    else if (wr_acc && ctrl_hit) ctrl_q <= bus_wdata[CTRL_W-1:0];
  end

  for (genvar i = 0; i < NTMR; i++) begin : g_tmr
    tmr_evt_t evt_i;
    logic     tick_i;

    assign tmr_hit[i] = (blk == BLK_W'(i));

    tmr_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (ext_tick[i]),
      .rise     (rise[i])
    );

    assign tick_i = ctrl_q[3*i+1] ? rise[i] : 1'b1;

    tmr_channel #(.CW(CW)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .en      (ctrl_q[3*i]),
      .up      (ctrl_q[3*NTMR+i]),
      .tick    (tick_i),
      .wr_en   (wr_acc && tmr_hit[i]),
      .wr_sel  (ofs),
      .wr_data (bus_wdata),
      .cnt     (cnt_v[i]),
      .load    (load_v[i]),
      .cmp1    (cmp1_v[i]),
      .cmp2    (cmp2_v[i]),
      .evt     (evt_i)
    );

    assign evt_all[3*i +: 3] = evt_i;
    assign gate[3*i +: 3]    = {ctrl_q[3*i+2], 2'b11};
  end

  tmr_irq_ctl #(.NEV(NEV)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .evt    (evt_all),
    .gate   (gate),
    .st_wr  (wr_acc && stat_hit),
    .msk_wr (wr_acc && mask_hit),
    .wdata  (bus_wdata[NEV-1:0]),
    .status (status_q),
    .mask   (mask_q),
    .irq    (irq)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NTMR; i++) begin
      if (blk == BLK_W'(i)) begin
        case (ofs)
          OFS_CNT:  rd_mux = cnt_v[i];
          OFS_LOAD: rd_mux = load_v[i];
          OFS_CMP1: rd_mux = cmp1_v[i];
          OFS_CMP2: rd_mux = cmp2_v[i];
          default:  rd_mux = '0;
        endcase
      end
    end
    if (ctrl_hit) rd_mux = {{(CW-CTRL_W){1'b0}}, ctrl_q};
    if (stat_hit) rd_mux = {{(CW-NEV){1'b0}}, status_q};
    if (mask_hit) rd_mux = {{(CW-NEV){1'b0}}, mask_q};
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_acc) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/trio_timer_chk.sv
module trio_timer_chk #(
  parameter int NTMR = 3,
  parameter int CW   = 32,
  parameter int AW   = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    bus_sel,
  input logic                    bus_wr,
  input logic [AW-1:0]           bus_addr,
  input logic [4*NTMR-1:0]       ctrl_q,
  input logic [NTMR-1:0][CW-1:0] cnt_v,
  input logic [NTMR-1:0][CW-1:0] load_v,
  input logic [3*NTMR-1:0]       status_q,
  input logic [3*NTMR-1:0]       mask_q,
  input logic                    irq
);
  localparam int NEV       = 3 * NTMR;
  localparam int STAT_ADDR = NTMR * 16 + 4;

  logic st_wr;
  assign st_wr = bus_sel && bus_wr && (bus_addr == AW'(STAT_ADDR));

  // R1: reset leaves mask all ones, status clear, irq low
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (mask_q == '1 && status_q == '0 && !irq));

  // R10: fully masked status never raises irq
  assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '1) |=> !irq);

  // R9: without a status write, no flag clears
  assert_sticky_status_R9: assert property (@(posedge clk) disable iff (rst)
    !st_wr |=> ((status_q & $past(status_q)) == $past(status_q)));

  for (genvar i = 0; i < NTMR; i++) begin : g_chk
    logic cnt_wr, run_clk;
    assign cnt_wr  = bus_sel && bus_wr && (bus_addr == AW'(16*i));
    assign run_clk = ctrl_q[3*i] && !ctrl_q[3*i+1] && !cnt_wr;

    assert_up_step_R3: assert property (@(posedge clk) disable iff (rst)
      (run_clk && ctrl_q[3*NTMR+i] && cnt_v[i] != '1)
        |=> (cnt_v[i] == $past(cnt_v[i]) + CW'(1)));

    assert_up_wrap_R3: assert property (@(posedge clk) disable iff (rst)
      (run_clk && ctrl_q[3*NTMR+i] && cnt_v[i] == '1)
        |=> (cnt_v[i] == $past(load_v[i]) && status_q[3*i+2]));

    assert_down_step_R4: assert property (@(posedge clk) disable iff (rst)
      (run_clk && !ctrl_q[3*NTMR+i] && cnt_v[i] != '0)
        |=> (cnt_v[i] == $past(cnt_v[i]) - CW'(1)));

    assert_down_wrap_R4: assert property (@(posedge clk) disable iff (rst)
      (run_clk && !ctrl_q[3*NTMR+i] && cnt_v[i] == '0)
        |=> (cnt_v[i] == $past(load_v[i]) && status_q[3*i+2]));

    assert_hold_disabled_R7: assert property (@(posedge clk) disable iff (rst)
      (!ctrl_q[3*i] && !cnt_wr) |=> $stable(cnt_v[i]));
  end

  logic unused_ok;
  assign unused_ok = ^{NEV[0]};
endmodule

bind trio_timer trio_timer_chk #(.NTMR(NTMR), .CW(CW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .ctrl_q   (ctrl_q),
  .cnt_v    (cnt_v),
  .load_v   (load_v),
  .status_q (status_q),
  .mask_q   (mask_q),
  .irq      (irq)
);

// File: tb/tb_trio_timer.sv
module tb_trio_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'h30, A_STAT = 8'h34, A_MASK = 8'h38;

  logic        clk = 1'b0, rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [2:0]  ext_tick = '0;
  logic        irq;
  int          n_vec = 0, n_bad = 0;
  bit          done = 0;

  trio_timer dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_tick(ext_tick), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  // Enable with control value v for exactly n ticks of the bus clock.
  task automatic run(input int n, input logic [31:0] v);
    wr(A_CTRL, v);
    repeat (n-1) @(negedge clk);
    wr(A_CTRL, 32'h0);
  endtask

  function automatic logic [31:0] nstep(input logic [31:0] c, input logic [31:0] l, input bit up);
    if (up) return (c == 32'hFFFF_FFFF) ? l : c + 1;
    else    return (c == 32'h0) ? l : c - 1;
  endfunction

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: run did not finish got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, c, st, start, l, m1, m2, base;
    repeat (4) @(negedge clk);
    rst = 0;

    // R1 / R2: reset state of every register
    for (int a = 0; a < 15; a++) begin
      rd(8'(a*4), d);
      check("R1 reset reg", d, (a == 14) ? 32'h1FF : 32'h0);
    end
    check("R1 reset irq", {31'b0, irq}, 32'h0);

    // R2: readback of reload/compare, control and mask fields
    for (int t = 0; t < 3; t++) begin
      base = 32'(t*16);
      wr(8'(base+4), 32'hA000_0000 | 32'(t*32'h111));
      wr(8'(base+8), 32'h5A5A_0000 + 32'(t));
      wr(8'(base+12), ~32'(t*7));
      rd(8'(base+4), d);  check("R2 reload", d, 32'hA000_0000 | 32'(t*32'h111));
      rd(8'(base+8), d);  check("R2 cmp1", d, 32'h5A5A_0000 + 32'(t));
      rd(8'(base+12), d); check("R2 cmp2", d, ~32'(t*7));
    end
    wr(A_CTRL, 32'hFFFF_FFB6); rd(A_CTRL, d); check("R2 ctrl", d, 32'hFB6);
    wr(A_CTRL, 0);
    wr(A_MASK, 32'hFFFF_F0AB); rd(A_MASK, d); check("R2 mask", d, 32'h0AB);
    wr(A_MASK, 32'h1FF);

    // R3 / R4 / R5: sweep timers, directions and run lengths across the wrap
    for (int t = 0; t < 3; t++)
      for (int dir = 0; dir < 2; dir++)
        for (int n = 1; n <= 6; n++) begin
          base  = 32'(t*16);
          start = dir ? 32'hFFFF_FFFD : 32'd2;
          l     = 32'h0001_0000 * 32'(t+1) + 32'(n);
          m1    = nstep(start, l, dir[0]);
          m2    = nstep(l, l, dir[0]);
          wr(A_CTRL, 0); wr(A_STAT, 0);
          wr(8'(base), start); wr(8'(base+4), l);
          wr(8'(base+8), m1);  wr(8'(base+12), m2);
          c = start; st = 0;
          for (int k = 0; k < n; k++) begin
            d = nstep(c, l, dir[0]);
            if ((dir != 0 && c == 32'hFFFF_FFFF) || (dir == 0 && c == 0)) st |= 32'(4 << (3*t));
            if (d == m1) st |= 32'(1 << (3*t));
            if (d == m2) st |= 32'(2 << (3*t));
            c = d;
          end
          run(n, 32'(1 << (3*t)) | (32'(dir) << (9+t)));
          rd(8'(base), d);
          check(dir ? "R3 up count" : "R4 down count", d, c);
          rd(A_STAT, d);
          check("R5 events", d, st);
        end

    // R6: live read and write over a running count
    wr(A_CTRL, 0); wr(8'h00, 32'd100);
    wr(A_CTRL, 32'h201);
    rd(8'h00, d); check("R6 live read", d, 32'd100);
    rd(8'h00, d); check("R6 live read next", d, 32'd101);
    wr(8'h00, 32'd500);
    wr(A_CTRL, 0);
    rd(8'h00, d); check("R6 write wins", d, 32'd501);

    // R7: disabled timer holds despite other control bits
    wr(8'h20, 32'h1234); wr(A_CTRL, 32'h880);
    repeat (20) @(negedge clk);
    rd(8'h20, d); check("R7 hold", d, 32'h1234);

    // R8: external source without edges does nothing, then counted edges
    wr(A_CTRL, 32'hC0);
    repeat (10) @(negedge clk);
    rd(8'h20, d); check("R8 no edge", d, 32'h1234);
    wr(A_CTRL, 0); wr(8'h10, 0);
    wr(A_CTRL, 32'h418);
    for (int p = 0; p < 5; p++) begin
      ext_tick[1] = 1; repeat (3) @(negedge clk);
      ext_tick[1] = 0; repeat (3) @(negedge clk);
    end
    ext_tick[1] = 1; repeat (10) @(negedge clk);
    repeat (5) @(negedge clk);
    rd(8'h10, d); check("R8 ext edges", d, 32'd6);
    ext_tick[1] = 0; wr(A_CTRL, 0);

    // R9: selective clear and event-over-clear
    wr(A_STAT, 0);
    wr(8'h10, 32'hFFFF_FFFE); wr(8'h14, 32'd5);
    wr(8'h18, 32'hFFFF_FFFF); wr(8'h1C, 32'd5);
    run(2, 32'h408);
    rd(A_STAT, d); check("R9 set", d, 32'h38);
    wr(A_STAT, ~32'h10);
    rd(A_STAT, d); check("R9 ones kept", d, 32'h28);
    wr(A_STAT, 0);
    rd(A_STAT, d); check("R9 zeros clear", d, 32'h0);
    wr(8'h10, 32'd10); wr(8'h18, 32'd12); wr(8'h1C, 32'd0); wr(8'h14, 32'd0);
    wr(A_CTRL, 32'h408);
    @(negedge clk);
    wr(A_STAT, 0);
    wr(A_CTRL, 0);
    rd(A_STAT, d); check("R9 event wins", d, 32'h08);
    wr(A_STAT, 0);

    // R10: interrupt masking and overflow gating
    wr(8'h00, 0); wr(8'h04, 0); wr(8'h08, 32'd3); wr(8'h0C, 32'hFFFF);
    run(3, 32'h201);
    repeat (2) @(negedge clk);
    check("R10 masked irq", {31'b0, irq}, 32'h0);
    rd(A_STAT, d); check("R10 status despite mask", d, 32'h1);
    wr(A_MASK, 32'h1FE);
    repeat (2) @(negedge clk);
    check("R10 unmasked irq", {31'b0, irq}, 32'h1);
    wr(A_STAT, 0);
    repeat (2) @(negedge clk);
    check("R10 cleared irq", {31'b0, irq}, 32'h0);
    wr(8'h00, 32'hFFFF_FFFF); wr(A_MASK, 32'h1FB);
    run(1, 32'h201);
    repeat (2) @(negedge clk);
    check("R10 ovf gated", {31'b0, irq}, 32'h0);
    wr(A_CTRL, 32'h4);
    repeat (2) @(negedge clk);
    check("R10 ovf enabled", {31'b0, irq}, 32'h1);
    wr(A_STAT, ~32'h4);
    repeat (2) @(negedge clk);
    check("R10 ovf cleared", {31'b0, irq}, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule